// File: doc/BRIEF.md
# 64-bit Single-Error-Correcting Check Codec

The codec takes a 64-bit data word and the 8-bit check byte stored alongside it. From the data it builds a fresh check byte using a fixed 8x64 parity-check matrix. It XORs that byte with the stored one to form the syndrome. It then decodes the syndrome to name one failing line, which is either a data line or a check line. The failing bit is flipped, and the block returns the corrected word, the corrected check byte and the line index.

The same freshly built check byte is also output on its own, so the block can produce the check code for words on the write side. Line numbers follow the memory-device view: data line 0 is the least significant data bit, and check line 0 is the least significant bit of the check byte.

Results are registered. They appear one clock after an input strobe, together with an output valid flag, and they hold between strobes.

Top module: `ecc_sec_codec`

## Requirements
- R1: After a synchronous reset, every output is zero and `out_valid` is low.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. All result outputs update on that same edge.
- R3: `out_gen` bit k is the XOR of the data bits selected by the 64-bit mask M_k, where mask bit n selects data bit n. The masks are: M0=f00fe11e_c33c0ff7, M1=00ff00ff_00fff0ff, M2=0f0f0f0f_0f0fff00, M3=11113333_7777000f, M4=22224444_8888222f, M5=44448888_ffff4441, M6=8888ffff_11118882, M7=ffff1111_22221114.
- R4: `out_syndrome` equals `out_gen` XOR the stored check byte that was presented with the same strobe.
- R5: A zero syndrome raises no flag. In that case the data and check byte pass through unchanged and `out_idx` is 0.
- R6: The column of data line i is the 8-bit value whose bit k is bit i of M_k. For a nonzero syndrome equal to a column, the lowest such i is the failing line. The block raises `out_err_data`, sets `out_idx`=i and flips data bit i. The check byte passes through unchanged.
- R7: A nonzero syndrome with no matching column and exactly one bit set names check line k, which is that bit. The block raises `out_err_chk`, sets `out_idx`=k and flips check bit k. The data passes through unchanged.
- R8: Any other nonzero syndrome raises `out_err_uncorr`. Data and check byte pass through unchanged and `out_idx` is 0.
- R9: While `in_valid` is low, changes on `in_data` and `in_chk` have no effect on any result output.
- R10: At most one of the three error flags is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_data | input | 64 | Received data word |
| in_chk | input | 8 | Stored check byte |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| out_data | output | 64 | Corrected data word |
| out_chk | output | 8 | Corrected check byte |
| out_gen | output | 8 | Check byte rebuilt from the input data |
| out_syndrome | output | 8 | Rebuilt XOR stored check byte |
| out_err_data | output | 1 | A data line was corrected |
| out_err_chk | output | 1 | A check line was corrected |
| out_err_uncorr | output | 1 | Error that cannot be located |
| out_idx | output | 6 | Failing data or check line number |

## Verification
A wrong mask bit in the encoder would show up as a wrong `out_gen` and `out_syndrome` in the cycle after any strobe whose data touches that bit. A fault in the column search would show as the wrong line flagged or flipped, and the wrong order in the search would show as a higher line winning over a lower one. A fault in the check-line decode, or in the pass-through on an uncorrectable syndrome, shows on the first word whose syndrome reaches that case. Every fault of this kind is visible one clock after the strobe. Output registers that fail to hold show on the first idle cycle in which the inputs move.

// File: rtl/ecc_sec_pkg.sv
package ecc_sec_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CIDX_W = $clog2(CHK_W);

  // Selection mask per check bit, entry k drives check bit k.
  localparam logic [DATA_W-1:0] CHK_MASK [CHK_W] = '{
    64'hf00fe11e_c33c0ff7,
    64'h00ff00ff_00fff0ff,
    64'h0f0f0f0f_0f0fff00,
    64'h11113333_7777000f,
    64'h22224444_8888222f,
    64'h44448888_ffff4441,
    64'h8888ffff_11118882,
    64'hffff1111_22221114
  };

  // Syndrome signature of a single failed data line.
  function automatic logic [CHK_W-1:0] column_of(input int line);
    logic [CHK_W-1:0] c;
    for (int k = 0; k < CHK_W; k++) c[k] = CHK_MASK[k][line];
    return c;
  endfunction

  typedef struct packed {
    logic              data_hit;
    logic              chk_hit;
    logic              uncorr;
    logic [IDX_W-1:0]  idx;
  } locate_t;
endpackage

// File: rtl/ecc_sec_encoder.sv
module ecc_sec_encoder
  import ecc_sec_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  for (genvar k = 0; k < CHK_W; k++) begin : g_bit
    assign chk[k] = ^(data & CHK_MASK[k]);
  end
endmodule

// File: rtl/ecc_sec_locator.sv
module ecc_sec_locator
  import ecc_sec_pkg::*;
(
  input  logic [CHK_W-1:0] syndrome,
  output locate_t          loc
);
  logic [DATA_W-1:0] col_match;
  logic              any_err;

  assign any_err = |syndrome;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] COL = column_of(i);
    assign col_match[i] = any_err && (syndrome == COL);
  end

  logic [IDX_W-1:0]  data_idx;
  logic [CIDX_W-1:0] chk_idx;
  logic              single;

  always_comb begin
    data_idx = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (col_match[i]) data_idx = IDX_W'(i);
  end

  always_comb begin
    chk_idx = '0;
    for (int k = CHK_W - 1; k >= 0; k--)
      if (syndrome[k]) chk_idx = CIDX_W'(k);
  end

  assign single = any_err && ((syndrome & (syndrome - 1'b1)) == '0);

  always_comb begin
    loc          = '0;
    loc.data_hit = |col_match;
    loc.chk_hit  = !loc.data_hit && single;
    loc.uncorr   = any_err && !loc.data_hit && !single;
    if (loc.data_hit)     loc.idx = data_idx;
    else if (loc.chk_hit) loc.idx = IDX_W'(chk_idx);
  end
endmodule

// File: rtl/ecc_sec_corrector.sv
module ecc_sec_corrector
  import ecc_sec_pkg::*;
(
  input  logic [DATA_W-1:0] data_in,
  input  logic [CHK_W-1:0]  chk_in,
  input  locate_t           loc,
  output logic [DATA_W-1:0] data_fix,
  output logic [CHK_W-1:0]  chk_fix
);
  logic [DATA_W-1:0] data_flip;
  logic [CHK_W-1:0]  chk_flip;

  for (genvar i = 0; i < DATA_W; i++) begin : g_dflip
    assign data_flip[i] = loc.data_hit && (loc.idx == IDX_W'(i));
  end
  for (genvar k = 0; k < CHK_W; k++) begin : g_cflip
    assign chk_flip[k] = loc.chk_hit && (loc.idx == IDX_W'(k));
  end

  assign data_fix = data_in ^ data_flip;
  assign chk_fix  = chk_in ^ chk_flip;
endmodule

// File: rtl/ecc_sec_codec.sv
module ecc_sec_codec
  import ecc_sec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CHK_W-1:0]  in_chk,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [CHK_W-1:0]  out_chk,
  output logic [CHK_W-1:0]  out_gen,
  output logic [CHK_W-1:0]  out_syndrome,
  output logic              out_err_data,
  output logic              out_err_chk,
  output logic              out_err_uncorr,
  output logic [IDX_W-1:0]  out_idx
);
  logic [CHK_W-1:0]  gen_c;
  logic [CHK_W-1:0]  syn_c;
  locate_t           loc_c;
  logic [DATA_W-1:0] data_c;
  logic [CHK_W-1:0]  chk_c;

  ecc_sec_encoder u_enc (.data(in_data), .chk(gen_c));

  assign syn_c = gen_c ^ in_chk;

  ecc_sec_locator u_loc (.syndrome(syn_c), .loc(loc_c));

  ecc_sec_corrector u_fix (
    .data_in (in_data),
    .chk_in  (in_chk),
    .loc     (loc_c),
    .data_fix(data_c),
    .chk_fix (chk_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_data       <= '0;
      out_chk        <= '0;
      out_gen        <= '0;
      out_syndrome   <= '0;
      out_err_data   <= 1'b0;
      out_err_chk    <= 1'b0;
      out_err_uncorr <= 1'b0;
      out_idx        <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data       <= data_c;
        out_chk        <= chk_c;
        out_gen        <= gen_c;
        out_syndrome   <= syn_c;
        out_err_data   <= loc_c.data_hit;
        out_err_chk    <= loc_c.chk_hit;
        out_err_uncorr <= loc_c.uncorr;
        out_idx        <= loc_c.idx;
      end
    end
  end
endmodule

// File: rtl/ecc_sec_codec_chk.sv
module ecc_sec_codec_chk
  import ecc_sec_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [CHK_W-1:0]  in_chk,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [CHK_W-1:0]  out_chk,
  input logic [CHK_W-1:0]  out_gen,
  input logic [CHK_W-1:0]  out_syndrome,
  input logic              out_err_data,
  input logic              out_err_chk,
  input logic              out_err_uncorr,
  input logic [IDX_W-1:0]  out_idx
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_syndrome_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_syndrome == (out_gen ^ $past(in_chk)));
  assert_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_syndrome == '0) |->
      (!out_err_data && !out_err_chk && !out_err_uncorr && out_idx == '0));
  assert_data_fix_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_err_data |-> ($countones(out_data ^ $past(in_data)) == 1
                                    && out_chk == $past(in_chk))));
  assert_chk_single_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err_chk) |-> $countones(out_syndrome) == 1);
  assert_uncorr_pass_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_err_uncorr |-> (out_data == $past(in_data)
                                      && out_chk == $past(in_chk) && out_idx == '0)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_chk) && $stable(out_syndrome)
                   && $stable(out_idx)));
  assert_one_flag_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_err_data, out_err_chk, out_err_uncorr}));
endmodule

bind ecc_sec_codec ecc_sec_codec_chk u_chk (.*);

// File: tb/ecc_sec_codec_tb.sv
`timescale 1ns/1ps
module ecc_sec_codec_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_data;
  logic [7:0]  in_chk;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_chk, out_gen, out_syndrome;
  logic        out_err_data, out_err_chk, out_err_uncorr;
  logic [5:0]  out_idx;

  always #2.5 clk = ~clk;

  ecc_sec_codec u_dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] masks [8];
  initial begin
    masks[0] = 64'hf00fe11ec33c0ff7; masks[1] = 64'h00ff00ff00fff0ff;
    masks[2] = 64'h0f0f0f0f0f0fff00; masks[3] = 64'h111133337777000f;
    masks[4] = 64'h222244448888222f; masks[5] = 64'h44448888ffff4441;
    masks[6] = 64'h8888ffff11118882; masks[7] = 64'hffff111122221114;
  end

  // expected model state
  logic        e_valid;
  logic [63:0] e_data;
  logic [7:0]  e_chk, e_gen, e_syn;
  logic        e_ed, e_ec, e_eu;
  int          e_idx;
  string       e_tag;

  function automatic logic [7:0] ref_gen(input logic [63:0] d);
    logic [7:0] g = 0;
    for (int k = 0; k < 8; k++) begin
      int p = 0;
      for (int n = 0; n < 64; n++) if (masks[k][n] && d[n]) p = p ^ 1;
      g[k] = p[0];
    end
    return g;
  endfunction

  task automatic model(input logic [63:0] d, input logic [7:0] c);
    int found = -1;
    e_gen = ref_gen(d);
    e_syn = e_gen ^ c;
    e_data = d; e_chk = c; e_ed = 0; e_ec = 0; e_eu = 0; e_idx = 0;
    for (int n = 0; n < 64 && found < 0; n++) begin
      logic [7:0] col;
      for (int k = 0; k < 8; k++) col[k] = masks[k][n];
      if (e_syn != 0 && col == e_syn) found = n;
    end
    if (e_syn == 0) e_tag = "R5";
    else if (found >= 0) begin
      e_tag = "R6"; e_ed = 1; e_idx = found; e_data[found] = ~e_data[found];
    end else if ($countones(e_syn) == 1) begin
      e_tag = "R7"; e_ec = 1;
      for (int k = 7; k >= 0; k--) if (e_syn[k]) e_idx = k;
      e_chk[e_idx] = ~e_chk[e_idx];
    end else begin
      e_tag = "R8"; e_eu = 1;
    end
  endtask

  task automatic chk1(input string what, input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk1("out_valid", e_tag == "R1" ? "R1" : "R2", out_valid, e_valid);
    chk1("out_gen", e_tag == "R1" ? "R1" : (e_tag == "R9" ? "R9" : "R3"), out_gen, e_gen);
    chk1("out_syndrome", e_tag == "R1" ? "R1" : (e_tag == "R9" ? "R9" : "R4"), out_syndrome, e_syn);
    chk1("out_data", e_tag, out_data, e_data);
    chk1("out_chk", e_tag, out_chk, e_chk);
    chk1("out_idx", e_tag, out_idx, e_idx);
    chk1("flags R10", e_tag, {out_err_data, out_err_chk, out_err_uncorr}, {e_ed, e_ec, e_eu});
  endtask

  // one cycle: check current outputs, then drive the next input
  task automatic step(input bit r, input bit v, input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    compare();
    rst = r; in_valid = v; in_data = d; in_chk = c;
    if (r) begin
      e_valid = 0; e_data = 0; e_chk = 0; e_gen = 0; e_syn = 0;
      e_ed = 0; e_ec = 0; e_eu = 0; e_idx = 0; e_tag = "R1";
    end else begin
      e_valid = v;
      if (v) model(d, c);
      else e_tag = "R9";
    end
  endtask

  task automatic send(input logic [63:0] d, input logic [7:0] c);
    step(0, 1, d, c);
  endtask

  initial begin
    logic [63:0] w;
    rst = 1; in_valid = 0; in_data = '1; in_chk = '1;
    e_valid = 0; e_data = 0; e_chk = 0; e_gen = 0; e_syn = 0;
    e_ed = 0; e_ec = 0; e_eu = 0; e_idx = 0; e_tag = "R1";
    @(negedge clk);
    // R1: reset state while inputs are busy
    step(1, 1, 64'hdeadbeef_01234567, 8'h5a);
    step(1, 0, 0, 0);
    // R3/R5: clean words
    send(64'h0, 8'h00);
    w = 64'h0123456789abcdef; send(w, ref_gen(w));
    w = 64'hffffffffffffffff; send(w, ref_gen(w));
    for (int n = 0; n < 64; n++) begin
      w = 64'h1 << n; send(w, ref_gen(w));   // R3 single-bit patterns
    end
    // R6: single data-line flips at boundaries and all lines
    for (int n = 0; n < 64; n++) begin
      w = {$urandom, $urandom};
      send(w ^ (64'h1 << n), ref_gen(w));
    end
    // R7: check-line flips
    for (int k = 0; k < 8; k++) begin
      w = {$urandom, $urandom};
      send(w, ref_gen(w) ^ (8'h1 << k));
    end
    // R8 and mixed: double flips and arbitrary check bytes
    for (int n = 0; n < 63; n++) begin
      w = {$urandom, $urandom};
      send(w ^ (64'h3 << n), ref_gen(w));
    end
    for (int n = 0; n < 256; n++) send({$urandom, $urandom}, 8'(n));
    // R9: idle cycles with moving inputs
    w = 64'h00000000_00000001; send(w, ref_gen(w));
    for (int n = 0; n < 6; n++) step(0, 0, {$urandom, $urandom}, 8'($urandom));
    send(64'h8000000000000000, 8'h00);
    step(0, 0, 64'h1, 8'hff);
    step(0, 0, 64'h2, 8'h0f);
    // back-to-back after idle
    send(64'hfedcba9876543210, 8'h00);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule